// File: doc/BRIEF.md
# Conflict-Free Bank Selector

This block sits in front of a group of slow interleaved memory banks that hold fixed-size packets whose departure slot is already known when they arrive. A memory access takes one whole frame of b slots. For every arriving packet the selector picks a bank that is not busy with another write this frame, not being read this frame, and not due to be read again in the packet's own departure frame. It keeps two pieces of state. The first is a departure map with one row for each frame slot, stored as a ring, holding one bit for each bank. The second is a vector that marks the banks already taken by writes in the current frame.

The bank count is fixed at 3b-1. This is one more than the largest number of banks that can be blocked when each frame has at most b writes, at most b reads, and at most b-1 other packets leaving in the same frame. Under those limits a free bank always exists. The block still reports when no bank is free. The caller supplies the current frame index and the departure frame index, both already wrapped to the ring size. The caller also pulses a frame-end strobe on the last slot of every frame.

Top module: `conflict_free_bank_pick`

## Requirements
- R1: After synchronous reset, `sel_valid`, `sel_found` and `sel_bank` are 0, and every bank is free in every frame row and in the write vector.
- R2: The number of banks is 3*`SLOTS_PER_FRAME`-1, and `sel_bank` always lies between 0 and that count minus 1.
- R3: A bank is a candidate only when it is clear in three places: the write vector, the row of `cur_frame` and the row of `dep_frame`. The chosen bank is the candidate with the lowest index.
- R4: The result for a request on `pkt_valid` is registered. `sel_valid` is high in exactly the cycle after the request and low after a cycle without one.
- R5: Once bank n is chosen, its write-vector bit is set, so later packets in the same frame avoid bank n.
- R6: Once bank n is chosen, bit n of the `dep_frame` row is set, so bank n is blocked for any later packet whose current frame or departure frame equals that frame.
- R7: `frame_end` clears the whole write vector at that clock edge.
- R8: `frame_end` clears the row of `cur_frame` at that clock edge, so the ring row can be reused when the frame index wraps.
- R9: When no bank is a candidate, `sel_found` is 0, `sel_bank` is 0, and neither the write vector nor any row changes.
- R10: A request in the same cycle as `frame_end` is decided on the state before the clear. The clears then take precedence over the bits that request would set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | A packet requests a bank this cycle |
| cur_frame | input | FRAME_BITS | Ring index of the current frame |
| dep_frame | input | FRAME_BITS | Ring index of the packet's departure frame |
| frame_end | input | 1 | Last slot of the current frame |
| sel_valid | output | 1 | Registered result strobe |
| sel_found | output | 1 | A conflict-free bank was found |
| sel_bank | output | $clog2(3*SLOTS_PER_FRAME-1) | Chosen bank index, 0 when none is found |

## Verification
The bench targets the cases where the three blocking sources overlap, and every one of them shows up as a wrong bank number. If the current-frame row were not consulted, a packet would land on a bank that is busy with a read. If the departure row were not updated, two packets leaving in the same frame would share a bank. A request that coincides with `frame_end` checks that the decision uses the state from before the clear; a design that cleared first would hand out a bank that is still taken. The bench also exhausts every bank and then steps the ring index back onto a cleared row. A failed pick that still wrote a bit, or a row that was never cleared, would then show up as a shifted bank index on the next requests. A sweep over every ring row, with varied departure distances, compares each pick against an arithmetic model.

// File: rtl/bsel_pkg.sv
package bsel_pkg;
  // Banks needed so that the worst-case set of blockers never covers them all.
  function automatic int bank_count(input int slots);
    return 3 * slots - 1;
  endfunction

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/bsel_lowest_free.sv
module bsel_lowest_free #(
  parameter int N  = 5,
  parameter int IW = 3
) (
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |cand;
    idx = '0;
    // Walk downward so the lowest set bit is the last one written.
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/bsel_rowstore.sv
module bsel_rowstore #(
  parameter int K  = 5,
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [FW-1:0] rd_a,
  input  logic [FW-1:0] rd_b,
  output logic [K-1:0]  row_a,
  output logic [K-1:0]  row_b,
  input  logic          set_en,
  input  logic [FW-1:0] set_row,
  input  logic [K-1:0]  set_mask,
  input  logic          clr_en,
  input  logic [FW-1:0] clr_row
);
  localparam int ROWS = 1 << FW;

  logic [K-1:0] rows [ROWS];

  // Two same-cycle read ports plus a clear: kept in fabric registers.
  assign row_a = rows[rd_a];
  assign row_b = rows[rd_b];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) rows[r] <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++) begin
        if (clr_en && clr_row == FW'(r))
          rows[r] <= '0;
        else if (set_en && set_row == FW'(r))
          rows[r] <= rows[r] | set_mask;
      end
    end
  end

  // R8
  row_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> rows[$past(clr_row)] == '0);

  // R6
  row_set_chk: assert property (@(posedge clk) disable iff (rst)
    (set_en && !(clr_en && clr_row == set_row))
      |=> (rows[$past(set_row)] & $past(set_mask)) == $past(set_mask));
endmodule

// File: rtl/conflict_free_bank_pick.sv
module conflict_free_bank_pick #(
  parameter int SLOTS_PER_FRAME = 2,
  parameter int FRAME_BITS      = 3,
  parameter int BANK_BITS       = bsel_pkg::idx_bits(bsel_pkg::bank_count(SLOTS_PER_FRAME))
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  pkt_valid,
  input  logic [FRAME_BITS-1:0] cur_frame,
  input  logic [FRAME_BITS-1:0] dep_frame,
  input  logic                  frame_end,
  output logic                  sel_valid,
  output logic                  sel_found,
  output logic [BANK_BITS-1:0]  sel_bank
);
  localparam int K = bsel_pkg::bank_count(SLOTS_PER_FRAME);

  logic [K-1:0]         w_vec;
  logic [K-1:0]         row_now, row_dep;
  logic [K-1:0]         blocked, cand, pick_mask;
  logic                 any_free;
  logic [BANK_BITS-1:0] pick_idx;
  logic                 take;

  bsel_rowstore #(.K(K), .FW(FRAME_BITS)) i_rows (
    .clk      (clk),
    .rst      (rst),
    .rd_a     (cur_frame),
    .rd_b     (dep_frame),
    .row_a    (row_now),
    .row_b    (row_dep),
    .set_en   (take),
    .set_row  (dep_frame),
    .set_mask (pick_mask),
    .clr_en   (frame_end),
    .clr_row  (cur_frame)
  );

  assign blocked = w_vec | row_now | row_dep;
  assign cand    = ~blocked;

  bsel_lowest_free #(.N(K), .IW(BANK_BITS)) i_pick (
    .cand (cand),
    .any  (any_free),
    .idx  (pick_idx)
  );

  assign take      = pkt_valid && any_free;
  assign pick_mask = any_free ? (K'(1) << pick_idx) : '0;

  always_ff @(posedge clk) begin
    if (rst)            w_vec <= '0;
    else if (frame_end) w_vec <= '0;
    else if (take)      w_vec <= w_vec | pick_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_valid <= 1'b0;
      sel_found <= 1'b0;
      sel_bank  <= '0;
    end else begin
      sel_valid <= pkt_valid;
      sel_found <= take;
      sel_bank  <= take ? pick_idx : '0;
    end
  end

  // R2
  bank_range_chk: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> int'(sel_bank) < K);

  // R3
  pick_free_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && sel_found) |-> ($past(blocked) & (K'(1) << sel_bank)) == '0);

  // R9
  none_free_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && !sel_found) |-> &$past(blocked));

  // R5
  write_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_valid && sel_found && !$past(frame_end)) |-> |(w_vec & (K'(1) << sel_bank)));

  // R7
  write_clear_chk: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> w_vec == '0);
endmodule

// File: tb/test_conflict_free_bank_pick.sv
module test_conflict_free_bank_pick;
  localparam int CLK_PERIOD = 10;
  localparam int B  = 2;
  localparam int K  = 3 * B - 1;
  localparam int FB = 3;
  localparam int NR = 1 << FB;
  localparam int BB = $clog2(K);

  logic          clk = 1'b0;
  logic          rst;
  logic          pkt_valid;
  logic [FB-1:0] cur_frame, dep_frame;
  logic          frame_end;
  logic          sel_valid, sel_found;
  logic [BB-1:0] sel_bank;

  int checks = 0;
  int errors = 0;

  logic [K-1:0] m_w;
  logic [K-1:0] m_r [NR];

  always #(CLK_PERIOD / 2) clk = ~clk;

  conflict_free_bank_pick #(.SLOTS_PER_FRAME(B), .FRAME_BITS(FB)) i_conflict_free_bank_pick (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .cur_frame(cur_frame),
    .dep_frame(dep_frame), .frame_end(frame_end),
    .sel_valid(sel_valid), .sel_found(sel_found), .sel_bank(sel_bank)
  );

  task automatic step(input logic v, input int f, input int d, input logic fe, input string tag);
    logic [K-1:0] blk;
    logic         e_found;
    int           e_bank;
    @(negedge clk);
    pkt_valid = v; cur_frame = FB'(f); dep_frame = FB'(d); frame_end = fe;
    blk = m_w | m_r[f] | m_r[d];
    e_found = (blk != '1);
    e_bank = 0;
    for (int i = K - 1; i >= 0; i--) if (!blk[i]) e_bank = i;
    if (v && e_found) begin
      m_w[e_bank] = 1'b1;
      m_r[d][e_bank] = 1'b1;
    end
    if (fe) begin
      m_w = '0;
      m_r[f] = '0;
    end
    @(posedge clk);
    #1;
    checks++;
    if (sel_valid !== v || (v && (sel_found !== e_found || int'(sel_bank) != e_bank))) begin
      errors++;
      $display("FAIL %s: f=%0d d=%0d actual valid=%0b found=%0b bank=%0d expected valid=%0b found=%0b bank=%0d",
               tag, f, d, sel_valid, sel_found, sel_bank, v, e_found, e_bank);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL R4 watchdog: actual hung expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_w = '0;
    for (int r = 0; r < NR; r++) m_r[r] = '0;
    rst = 1'b1; pkt_valid = 1'b0; cur_frame = '0; dep_frame = '0; frame_end = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    checks++;
    if (sel_valid !== 1'b0 || sel_found !== 1'b0 || sel_bank !== '0) begin
      errors++;
      $display("FAIL R1 reset: actual %0b %0b %0d expected 0 0 0", sel_valid, sel_found, sel_bank);
    end
    // R1 R3: empty state gives bank 0; R5 R6 next ones skip taken banks
    step(1, 0, 3, 0, "R1 first pick");
    step(1, 0, 3, 0, "R5 same frame skip");
    step(1, 0, 5, 0, "R5 write vector");
    step(0, 0, 0, 0, "R4 idle cycle");
    step(1, 0, 3, 1, "R10 pick with frame_end");
    // R7: write vector empty, R6: departure row 3 holds banks 0,1,3
    step(1, 1, 3, 0, "R6 departure row");
    step(1, 1, 5, 1, "R7 cleared writes");
    // R3: current-frame row 3 blocks reads of this frame
    step(1, 3, 4, 0, "R3 read row of current frame");
    step(1, 3, 4, 0, "R9 no free bank");
    step(1, 3, 6, 1, "R9 no free bank at frame end");
    // R8: row 3 reused after clear; R9: row 6 unchanged by failed pick
    step(1, 4, 3, 0, "R8 reused row");
    step(1, 4, 6, 0, "R9 untouched row");
    step(0, 4, 0, 1, "R7 frame end idle");
    step(1, 5, 7, 1, "R2 R3 single pick");
    // sweep all ring rows with varied departure distances
    for (int rnd = 0; rnd < 4; rnd++) begin
      for (int f = 0; f < NR; f++) begin
        for (int s = 0; s <= B; s++)
          step(1, f, (f + 1 + ((rnd * 7 + f * 3 + s * 5) % 7)) % NR, 0, "R3 R5 R6 sweep");
        step((f % 2) == 1, f, (f + 2 + rnd) % NR, 1, "R7 R8 R10 sweep");
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule